// File: doc/BRIEF.md
# Network Controller Indirect Status Register Block

This block is the host-facing register window of a network controller. The host first loads a small pointer register, which chooses one of four control/status words. A separate data port then reads or writes the word that the pointer selects. Word 0 is the main control/status word. Words 1 to 3 are plain storage for neighbouring logic.

The transmitter and receiver engines report faults as single-cycle pulses. The block latches each pulse into a sticky flag. The host clears a flag by writing 1 to its bit. A read-only summary bit shows whether any flag is still set. An interrupt line is raised only for the fault types that may interrupt, and only while the interrupt enable is set. Writing the stop bit discards every pending flag.

Top module: `ctl_status_regs`

## Requirements
- R1: With `host_sel`=0, writes load the pointer from `host_wdata[1:0]`, and bits above are discarded. Pointer reads return the selection in bits 1:0 with zeros above. Reset sets the pointer to 0.
- R2: With `host_sel`=1 and pointer 1, 2 or 3, the data port writes and reads a 16-bit storage word. These words reset to 0, and writing one of them leaves word 0 unchanged.
- R3: A pulse on `ev_babble`, `ev_coll`, `ev_miss` or `ev_mem` sets the flag in word 0 at bit 14, 13, 12 or 11 respectively. The flag stays set after the pulse ends.
- R4: A word-0 write with 1 in a flag bit clears that flag. A 0 in a flag bit leaves it unchanged.
- R5: Bit 15 of word 0 reads 1 while any of the four flags is set, and 0 otherwise. Writes to bit 15 have no effect.
- R6: Bit 0 of word 0 is the stop bit and bit 1 is the interrupt enable; both are loaded by word-0 writes. Any word-0 write with bit 0 = 1 clears all four flags. After reset, word 0 reads 0x0001.
- R7: When an event pulse and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R8: `irq` is 1 exactly when the interrupt enable is 1 and at least one of the babble, missed-packet or memory-error flags is set. The collision flag never raises `irq`.
- R9: `host_rdata` is loaded on the clock edge that samples `host_rd`=1 and holds its value otherwise. Bits 10:2 of word 0 always read 0, whatever was written to them.
- R10: When a stop write coincides with event pulses, all flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | 0 = pointer register, 1 = data port |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Registered read data |
| ev_babble | input | 1 | Transmit overlength event pulse |
| ev_coll | input | 1 | Missing collision-test event pulse |
| ev_miss | input | 1 | Dropped receive frame event pulse |
| ev_mem | input | 1 | Memory access fault event pulse |
| irq | output | 1 | Level interrupt request |

## Verification
A lost or stuck flag is visible at the next data-port read of word 0, one cycle after the read strobe. The same fault shows in bit 15 and on `irq` in the cycle after the event or write edge. The pointer cannot be observed directly: a corrupted pointer shows up only as the wrong word returned on the next data read. For that reason, the bench follows every pointer change with a read of a known storage value. Same-cycle collisions of events, clears and stop writes are driven on purpose, because a wrong priority shows only in those cycles.

// File: rtl/csr_pkg.sv
`timescale 1ns/1ps
package csr_pkg;
  localparam int NFLAG    = 4;
  localparam int BIT_ERR  = 15;
  localparam int BIT_BABL = 14;
  localparam int BIT_MERR = 11;
  localparam int BIT_IEN  = 1;
  localparam int BIT_STOP = 0;
  // flag index order: babble, collision, missed, memory
  localparam logic [NFLAG-1:0] IRQ_CAP = 4'b1101;

  function automatic int flag_bit(input int idx);
    return BIT_BABL - idx;
  endfunction
endpackage

// File: rtl/csr_sticky_flag.sv
`timescale 1ns/1ps
module csr_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic kill_i,
  output logic q_o
);
  // stop clear beats event; event beats host clear
  always_ff @(posedge clk) begin
    if (rst || kill_i)  q_o <= 1'b0;
    else if (set_i)     q_o <= 1'b1;
    else if (clr_i)     q_o <= 1'b0;
  end
endmodule

// File: rtl/csr_ptr_reg.sv
`timescale 1ns/1ps
module csr_ptr_reg #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wdata,
  output logic [SEL_W-1:0] sel_o
);
  always_ff @(posedge clk) begin
    if (rst)        sel_o <= '0;
    else if (wr_en) sel_o <= wdata;
  end
endmodule

// File: rtl/csr_store_bank.sv
`timescale 1ns/1ps
module csr_store_bank #(
  parameter int DATA_W  = 16,
  parameter int NUM_CSR = 4,
  localparam int SEL_W  = $clog2(NUM_CSR)
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [SEL_W-1:0]                    sel,
  input  logic [DATA_W-1:0]                   wdata,
  output logic [NUM_CSR-1:1][DATA_W-1:0]      words_o
);
  for (genvar i = 1; i < NUM_CSR; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                                 words_o[i] <= '0;
      else if (wr_en && sel == SEL_W'(i))      words_o[i] <= wdata;
    end
  end
endmodule

// File: rtl/csr_main_reg.sv
`timescale 1ns/1ps
module csr_main_reg
  import csr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NFLAG-1:0]  ev_i,
  output logic [DATA_W-1:0] word_o,
  output logic [NFLAG-1:0]  flags_o,
  output logic              ien_o,
  output logic              irq_o
);
  logic stop_q;
  logic stop_req;
  logic summary;
  logic unused_wbits;

  assign stop_req = wr_en & wdata[BIT_STOP];

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    csr_sticky_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (ev_i[g]),
      .clr_i  (wr_en & wdata[flag_bit(g)]),
      .kill_i (stop_req),
      .q_o    (flags_o[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q <= 1'b1;
      ien_o  <= 1'b0;
    end else if (wr_en) begin
      stop_q <= wdata[BIT_STOP];
      ien_o  <= wdata[BIT_IEN];
    end
  end

  assign summary = |flags_o;
  assign irq_o   = ien_o & |(flags_o & IRQ_CAP);

  always_comb begin
    word_o           = '0;
    word_o[BIT_ERR]  = summary;
    for (int i = 0; i < NFLAG; i++) word_o[flag_bit(i)] = flags_o[i];
    word_o[BIT_IEN]  = ien_o;
    word_o[BIT_STOP] = stop_q;
  end

  assign unused_wbits = ^{wdata[DATA_W-1:BIT_ERR], wdata[BIT_MERR-1:BIT_IEN+1]};
endmodule

// File: rtl/ctl_status_regs.sv
`timescale 1ns/1ps
module ctl_status_regs
  import csr_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_CSR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              ev_babble,
  input  logic              ev_coll,
  input  logic              ev_miss,
  input  logic              ev_mem,
  output logic              irq
);
  localparam int SEL_W = $clog2(NUM_CSR);

  logic [SEL_W-1:0]                 ptr_q;
  logic                             wr_ptr, wr_dat, wr_c0;
  logic [NFLAG-1:0]                 ev_vec;
  logic [NFLAG-1:0]                 flags;
  logic                             ien;
  logic [DATA_W-1:0]                c0_word;
  logic [NUM_CSR-1:1][DATA_W-1:0]   bank_words;
  logic [NUM_CSR-1:0][DATA_W-1:0]   all_words;

  assign wr_ptr = host_wr & ~host_sel;
  assign wr_dat = host_wr &  host_sel;
  assign wr_c0  = wr_dat & (ptr_q == '0);
  assign ev_vec = {ev_mem, ev_miss, ev_coll, ev_babble};

  csr_ptr_reg #(.SEL_W(SEL_W)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_ptr),
    .wdata (host_wdata[SEL_W-1:0]),
    .sel_o (ptr_q)
  );

  csr_main_reg #(.DATA_W(DATA_W)) u_main (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_c0),
    .wdata   (host_wdata),
    .ev_i    (ev_vec),
    .word_o  (c0_word),
    .flags_o (flags),
    .ien_o   (ien),
    .irq_o   (irq)
  );

  csr_store_bank #(.DATA_W(DATA_W), .NUM_CSR(NUM_CSR)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_dat),
    .sel     (ptr_q),
    .wdata   (host_wdata),
    .words_o (bank_words)
  );

  always_comb begin
    all_words[0] = c0_word;
    for (int i = 1; i < NUM_CSR; i++) all_words[i] = bank_words[i];
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= host_sel ? all_words[ptr_q] : DATA_W'(ptr_q);
  end
endmodule

// File: rtl/csr_chk.sv
`timescale 1ns/1ps
module csr_chk
  import csr_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        wr_c0,
  input logic [15:0] host_wdata,
  input logic [1:0]  ptr_q,
  input logic [3:0]  ev_vec,
  input logic [3:0]  flags,
  input logic        ien,
  input logic        irq
);
  // R1
  ptr_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ptr_q == 2'd0);
  // R3
  ev_latch_chk: assert property (@(posedge clk) disable iff (rst)
    ev_vec[0] && !(wr_c0 && host_wdata[BIT_STOP]) |=> flags[0]);
  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_c0 && host_wdata[BIT_BABL] && !ev_vec[0] |=> !flags[0]);
  // R4
  w0_keep_chk: assert property (@(posedge clk) disable iff (rst)
    wr_c0 && !host_wdata[BIT_BABL] && !host_wdata[BIT_STOP] && flags[0] |=> flags[0]);
  // R6
  stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_c0 && host_wdata[BIT_STOP] |=> $countones(flags) == 0);
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !ien |-> !irq);
  // R8
  coll_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    flags == 4'b0010 |-> !irq);
endmodule

bind ctl_status_regs csr_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .wr_c0      (wr_c0),
  .host_wdata (host_wdata),
  .ptr_q      (ptr_q),
  .ev_vec     (ev_vec),
  .flags      (flags),
  .ien        (ien),
  .irq        (irq)
);

// File: tb/ctl_status_regs_tb_top.sv
`timescale 1ns/1ps
module ctl_status_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        ev_babble = 1'b0, ev_coll = 1'b0, ev_miss = 1'b0, ev_mem = 1'b0;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        mon_rd = 1'b0;

  always #2.5 clk = ~clk;

  ctl_status_regs dut_i (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ev_babble(ev_babble),
    .ev_coll(ev_coll), .ev_miss(ev_miss), .ev_mem(ev_mem), .irq(irq)
  );

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // monitor: read issued at posedge, result due at following negedge
  always @(posedge clk) mon_rd <= host_rd;
  always @(negedge clk) begin
    if (mon_rd) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R9 unexpected read got=%h exp=none", host_rdata);
      end else begin
        chk(host_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic set_ev(input logic [3:0] m);
    {ev_mem, ev_miss, ev_coll, ev_babble} = m;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr_ev(input logic sel, input logic [15:0] d, input logic [3:0] m);
    @(negedge clk);
    host_sel = sel; host_wr = 1'b1; host_wdata = d; set_ev(m);
    @(negedge clk);
    host_wr = 1'b0; set_ev(4'b0);
  endtask

  task automatic wr_ptr(input logic [15:0] d); wr_ev(1'b0, d, 4'b0); endtask
  task automatic wr_dat(input logic [15:0] d); wr_ev(1'b1, d, 4'b0); endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk); set_ev(m);
    @(negedge clk); set_ev(4'b0);
  endtask

  task automatic rd(input logic sel, input logic [15:0] e, input string tag);
    @(negedge clk);
    host_sel = sel; host_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    chk({15'b0, irq}, {15'b0, e}, tag);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=hung exp=done");
      finish_run();
    end
  end

  initial begin
    do_reset();
    rd(1'b0, 16'h0000, "R1 pointer after reset");
    rd(1'b1, 16'h0001, "R6 word0 after reset");
    chk_irq(1'b0, "R8 irq after reset");

    wr_ptr(16'hFFF2);
    rd(1'b0, 16'h0002, "R1 pointer upper bits dropped");
    wr_dat(16'hA5C3);
    wr_ptr(16'h0001); wr_dat(16'h1234);
    wr_ptr(16'h0003); wr_dat(16'hFFFF);
    rd(1'b1, 16'hFFFF, "R2 word3");
    wr_ptr(16'h0001); rd(1'b1, 16'h1234, "R2 word1");
    wr_ptr(16'h0002); rd(1'b1, 16'hA5C3, "R2 word2");
    wr_ptr(16'h0000); rd(1'b1, 16'h0001, "R2 word0 untouched");

    wr_dat(16'h0002);
    rd(1'b1, 16'h0002, "R6 stop and enable loaded");
    pulse(4'b0010);
    chk_irq(1'b0, "R8 collision gives no irq");
    rd(1'b1, 16'hA002, "R3 collision latched");
    pulse(4'b0001);
    chk_irq(1'b1, "R8 babble irq");
    rd(1'b1, 16'hE002, "R3 babble latched");
    wr_dat(16'h8002);
    rd(1'b1, 16'hE002, "R5 summary write ignored, R4 zeros keep");
    wr_dat(16'h4002);
    chk_irq(1'b0, "R8 irq drops after clear");
    rd(1'b1, 16'hA002, "R4 babble cleared");
    wr_dat(16'h2002);
    rd(1'b1, 16'h0002, "R5 summary clears with last flag");

    pulse(4'b0100);
    chk_irq(1'b1, "R8 missed irq");
    rd(1'b1, 16'h9002, "R3 missed latched");
    wr_dat(16'h0000);
    chk_irq(1'b0, "R8 enable off masks irq");
    rd(1'b1, 16'h9000, "R4 zero write keeps flag");
    wr_dat(16'h0002);
    chk_irq(1'b1, "R8 enable on restores irq");

    wr_ev(1'b1, 16'h1802, 4'b1100);
    rd(1'b1, 16'h9802, "R7 set beats clear");

    wr_dat(16'h0003);
    chk_irq(1'b0, "R6 stop drops irq");
    rd(1'b1, 16'h0003, "R6 stop clears flags");
    wr_ev(1'b1, 16'h0003, 4'b1111);
    rd(1'b1, 16'h0003, "R10 stop beats events");

    wr_dat(16'h07FE);
    rd(1'b1, 16'h0002, "R9 unused bits read zero");
    pulse(4'b1000);
    chk(host_rdata, 16'h0002, "R9 rdata holds without read");
    chk_irq(1'b1, "R8 memory error irq");
    rd(1'b1, 16'h8802, "R3 memory error latched");

    wr_ptr(16'h0001); wr_dat(16'hBEEF);
    do_reset();
    chk_irq(1'b0, "R8 irq cleared by reset");
    rd(1'b0, 16'h0000, "R1 pointer cleared by reset");
    rd(1'b1, 16'h0001, "R6 word0 reset value");
    wr_ptr(16'h0001);
    rd(1'b1, 16'h0000, "R2 storage cleared by reset");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R9 pending reads got=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule